// File: doc/BRIEF.md
# Two-Wire Slave Receiver Status Engine

This block is the receive side of a slave on a two-wire serial bus. It samples the bus clock and data lines with the system clock and finds start, repeated-start and stop conditions. It collects the address byte and compares it with a programmable own address and with the general-call address. It then shifts in data bytes and drives the acknowledge bit as software asks through an acknowledge-enable input.

Each significant bus event ends with an 8-bit status code and a raised interrupt flag. While the flag is up the block holds the clock line low, so the transmitting master waits. Software reads the code and the received byte, sets the acknowledge policy for the next byte, and clears the flag with a one-cycle pulse. An input from the master side reports lost arbitration, which selects separate codes for the address phase.

Top module: `twi_slave_rx`

## Requirements
- R1: After a synchronous reset, status reads F8h, the flag is low, and neither bus line is pulled low.
- R2: An address byte carries the 7-bit address MSB first and then a direction bit, where 0 means write. A nonzero address equal to `own_addr` with direction 0, and `ack_enable` high when the 8th bit ends, is acknowledged. The block then reports 60h, or 68h if `arb_lost` is high at that moment. `rx_data` holds the address byte.
- R3: Address 00h with direction 0 and `gc_enable` high is a general call. When acknowledged it reports 70h, or 78h with `arb_lost` high.
- R4: After an own-address match, a data byte received with `ack_enable` high is acknowledged and reports 80h. With `ack_enable` low, SDA is left released and the code is 88h. In both cases `rx_data` holds the byte.
- R5: After a general call, data bytes report 90h when acknowledged and 98h when not.
- R6: Any number of acknowledged data bytes may follow one address, and each one reports its 80h or 90h code again.
- R7: A stop or a repeated start seen while addressed reports A0h. After a repeated start, a new address byte is received normally.
- R8: After 88h or 98h the block is no longer addressed. Later bytes get no acknowledge and no flag, and the following stop or start gives no A0h.
- R9: A byte with a different address, direction 1, address 00h with `gc_enable` low, or `ack_enable` low at the address is ignored. There is no acknowledge, no flag, and status stays F8h.
- R10: While the flag is set, SCL is held low. A `flag_clear` pulse drops the flag, releases SCL and returns status to F8h.
- R11: The block changes its SDA drive only while SCL is low. It pulls SDA low from the clock fall after the 8th bit to the clock fall after the 9th bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| own_addr | input | 7 | Slave address this block answers to |
| gc_enable | input | 1 | Allows the general-call address to be accepted |
| ack_enable | input | 1 | Acknowledge policy for the byte currently being received |
| arb_lost | input | 1 | High when the local master has just lost arbitration |
| flag_clear | input | 1 | One-cycle pulse that clears the interrupt flag |
| scl_drive_low | output | 1 | Pull the clock line low (clock stretching) |
| sda_drive_low | output | 1 | Pull the data line low (acknowledge) |
| irq_flag | output | 1 | Interrupt flag, set with each new status code |
| status | output | 8 | Current status code |
| rx_data | output | 8 | Last byte accepted on the bus |

## Verification
The bench sends the last acknowledged byte followed by a not-acknowledged one, then more bytes and a stop. A design that kept acknowledging, or that reported A0h after the refusal, would show a stray acknowledge or flag. Repeated start is tested both as an ending and as the way into a new address: a design that ignored it while addressed, or lost the new address byte behind the A0h stretch, would miss the following 60h. The rejected cases are a neighbouring address, the read direction, a disabled general call and a refused address. Each would expose a loose comparator as an acknowledge on the wire. Arbitration-loss codes and random byte counts, acknowledge patterns and endings cover the remaining code table.

// File: rtl/twi_srx_pkg.sv
package twi_srx_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;

    typedef logic [7:0] stat_t;

    localparam stat_t ST_OWN_ADDR      = 8'h60;
    localparam stat_t ST_OWN_ADDR_ARB  = 8'h68;
    localparam stat_t ST_GC_ADDR       = 8'h70;
    localparam stat_t ST_GC_ADDR_ARB   = 8'h78;
    localparam stat_t ST_OWN_DATA_ACK  = 8'h80;
    localparam stat_t ST_OWN_DATA_NACK = 8'h88;
    localparam stat_t ST_GC_DATA_ACK   = 8'h90;
    localparam stat_t ST_GC_DATA_NACK  = 8'h98;
    localparam stat_t ST_END_OF_XFER   = 8'hA0;
    localparam stat_t ST_NOTHING       = 8'hF8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_ACK
    } phase_t;

    typedef enum logic [1:0] {
        AM_NONE,
        AM_OWN,
        AM_GCALL
    } amatch_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic amatch_t classify_addr(
        input logic [BYTE_W-1:0] b,
        input logic [ADDR_W-1:0] own,
        input logic              gc_en
    );
        if (b[0]) return AM_NONE;
        if (b[BYTE_W-1:1] == '0) return gc_en ? AM_GCALL : AM_NONE;
        if (b[BYTE_W-1:1] == own) return AM_OWN;
        return AM_NONE;
    endfunction

    function automatic stat_t addr_code(input amatch_t m, input logic arb);
        if (m == AM_GCALL) return arb ? ST_GC_ADDR_ARB : ST_GC_ADDR;
        return arb ? ST_OWN_ADDR_ARB : ST_OWN_ADDR;
    endfunction

    function automatic stat_t data_code(input logic gc, input logic ack);
        if (gc) return ack ? ST_GC_DATA_ACK : ST_GC_DATA_NACK;
        return ack ? ST_OWN_DATA_ACK : ST_OWN_DATA_NACK;
    endfunction

endpackage

// File: rtl/twi_srx_sync.sv
module twi_srx_sync
    import twi_srx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[STAGES-1];
        ev.sda      = sda_pipe[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

endmodule

// File: rtl/twi_srx_shift.sv
module twi_srx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            data <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (sample && !full) begin
            data <= {data[W-2:0], bit_in};
            cnt  <= cnt + CW'(1);
        end
    end

    assign full = (cnt == CW'(W));

endmodule

// File: rtl/twi_srx_ctrl.sv
module twi_srx_ctrl
    import twi_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              byte_full,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              arb_lost,
    input  logic              flag_clear,
    output logic              shift_clr,
    output logic              shift_en,
    output logic              sda_low,
    output logic              scl_low,
    output logic              flag,
    output stat_t             status,
    output logic [BYTE_W-1:0] rx_data
);
    phase_t  phase;
    amatch_t am;
    logic    engaged;
    logic    gc_sel;
    logic    stay;
    stat_t   pend;
    logic    byte_end;

    always_comb begin
        am        = classify_addr(byte_val, own_addr, gc_en);
        byte_end  = ev.scl_fall && byte_full;
        shift_en  = ev.scl_rise && (phase == PH_ADDR || phase == PH_DATA);
        shift_clr = ev.start || ev.stop || (phase == PH_ACK && ev.scl_fall);
        scl_low   = flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            engaged <= 1'b0;
            gc_sel  <= 1'b0;
            stay    <= 1'b0;
            sda_low <= 1'b0;
            pend    <= ST_NOTHING;
            flag    <= 1'b0;
            status  <= ST_NOTHING;
            rx_data <= '0;
        end else begin
            if (flag_clear) begin
                flag   <= 1'b0;
                status <= ST_NOTHING;
            end
            if (ev.start || ev.stop) begin
                sda_low <= 1'b0;
                phase   <= ev.start ? PH_ADDR : PH_IDLE;
                engaged <= 1'b0;
                if (engaged) begin
                    flag   <= 1'b1;
                    status <= ST_END_OF_XFER;
                end
            end else begin
                case (phase)
                    PH_ADDR: begin
                        if (byte_end) begin
                            if (am != AM_NONE && ack_en) begin
                                sda_low <= 1'b1;
                                phase   <= PH_ACK;
                                pend    <= addr_code(am, arb_lost);
                                gc_sel  <= (am == AM_GCALL);
                                stay    <= 1'b1;
                                engaged <= 1'b1;
                                rx_data <= byte_val;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (byte_end) begin
                            sda_low <= ack_en;
                            phase   <= PH_ACK;
                            pend    <= data_code(gc_sel, ack_en);
                            stay    <= ack_en;
                            rx_data <= byte_val;
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            sda_low <= 1'b0;
                            flag    <= 1'b1;
                            status  <= pend;
                            engaged <= stay;
                            phase   <= stay ? PH_DATA : PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_slave_rx.sv
module twi_slave_rx
    import twi_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               scl_in,
    input  logic                               sda_in,
    input  logic [twi_srx_pkg::ADDR_W-1:0]     own_addr,
    input  logic                               gc_enable,
    input  logic                               ack_enable,
    input  logic                               arb_lost,
    input  logic                               flag_clear,
    output logic                               scl_drive_low,
    output logic                               sda_drive_low,
    output logic                               irq_flag,
    output logic [7:0]                         status,
    output logic [twi_srx_pkg::BYTE_W-1:0]     rx_data
);
    bus_ev_t           bus_ev;
    logic              shift_clr;
    logic              shift_en;
    logic [BYTE_W-1:0] byte_val;
    logic              byte_full;

    twi_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ev      (bus_ev)
    );

    twi_srx_shift #(.W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr    (shift_clr),
        .sample (shift_en),
        .bit_in (bus_ev.sda),
        .data   (byte_val),
        .full   (byte_full)
    );

    twi_srx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (bus_ev),
        .byte_val   (byte_val),
        .byte_full  (byte_full),
        .own_addr   (own_addr),
        .gc_en      (gc_enable),
        .ack_en     (ack_enable),
        .arb_lost   (arb_lost),
        .flag_clear (flag_clear),
        .shift_clr  (shift_clr),
        .shift_en   (shift_en),
        .sda_low    (sda_drive_low),
        .scl_low    (scl_drive_low),
        .flag       (irq_flag),
        .status     (status),
        .rx_data    (rx_data)
    );

endmodule

// File: rtl/twi_slave_rx_chk.sv
module twi_slave_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_sync,
    input logic       sda_drive_low,
    input logic       irq_flag,
    input logic       flag_clear,
    input logic [7:0] status
);
    // R10: with the flag down the status register shows the idle code
    a_r10_idle_code: assert property (@(posedge clk) disable iff (rst)
        !irq_flag |-> status == 8'hF8);

    // R10: the flag only drops after a clear pulse
    a_r10_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> $past(flag_clear));

    // R11: SDA drive changes only while the synchronised clock is low
    a_r11_sda_when_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_sync);

    // R2..R7: a freshly raised flag carries a defined slave-receive code
    a_r4_code_legal: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> (status == 8'h60 || status == 8'h68 ||
                             status == 8'h70 || status == 8'h78 ||
                             status == 8'h80 || status == 8'h88 ||
                             status == 8'h90 || status == 8'h98 ||
                             status == 8'hA0));

    // R8: a refused byte leaves the data line released
    a_r8_nack_released: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_flag) && (status == 8'h88 || status == 8'h98)) |-> !sda_drive_low);

endmodule

bind twi_slave_rx twi_slave_rx_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_sync      (bus_ev.scl),
    .sda_drive_low (sda_drive_low),
    .irq_flag      (irq_flag),
    .flag_clear    (flag_clear),
    .status        (status)
);

// File: tb/tb_twi_slave_rx.sv
module tb_twi_slave_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] own_addr = 7'h5A;
    logic       gc_enable = 1'b1;
    logic       ack_enable = 1'b1;
    logic       arb_lost = 1'b0;
    logic       flag_clear = 1'b0;
    logic       scl_drive_low, sda_drive_low, irq_flag;
    logic [7:0] status, rx_data;
    logic       scl_line, sda_line;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  r11_viol = 0;
    bit  finished = 1'b0;
    logic sda_drv_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    twi_slave_rx dut (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .own_addr(own_addr), .gc_enable(gc_enable), .ack_enable(ack_enable),
        .arb_lost(arb_lost), .flag_clear(flag_clear),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .irq_flag(irq_flag), .status(status), .rx_data(rx_data)
    );

    // R11 monitor: data drive may change only while the clock line is low
    always @(negedge clk) begin
        if (!rst && sda_drive_low != sda_drv_prev && scl_line) r11_viol++;
        sda_drv_prev <= sda_drive_low;
    end

    function automatic logic [7:0] exp_addr(input bit gc, input bit arb);
        if (gc) return arb ? 8'h78 : 8'h70;
        return arb ? 8'h68 : 8'h60;
    endfunction

    function automatic logic [7:0] exp_data(input bit gc, input bit ack);
        if (gc) return ack ? 8'h90 : 8'h98;
        return ack ? 8'h80 : 8'h88;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_clk(HALF); sda_m = 1'b0; wait_clk(HALF); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(2); sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_scl_high(); wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic bus_rstart();
        wait_clk(2); sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_scl_high(); wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(2); sda_m = b[i]; wait_clk(HALF);
            scl_m = 1'b1; wait_scl_high(); wait_clk(HALF); scl_m = 1'b0;
        end
        wait_clk(2); sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_scl_high(); wait_clk(HALF/2);
        acked = !sda_line;
        wait_clk(HALF/2); scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic sw_expect(input logic [7:0] code, input string req,
                             input logic [7:0] exp_rx, input bit chk_rx);
        int t = 0;
        while (!irq_flag && t < 40) begin wait_clk(1); t++; end
        check(irq_flag == 1'b1, req, irq_flag, 1);
        check(status == code, req, status, code);
        wait_clk(6);
        check(scl_drive_low && !scl_line, "R10 stretch", scl_line, 0);
        if (chk_rx) check(rx_data == exp_rx, req, rx_data, exp_rx);
        flag_clear = 1'b1; wait_clk(1); flag_clear = 1'b0; wait_clk(1);
        check(!irq_flag && status == 8'hF8, "R10 clear", status, 8'hF8);
        check(!scl_drive_low, "R10 release", scl_drive_low, 0);
    endtask

    task automatic sw_expect_none(input string req);
        wait_clk(20);
        check(!irq_flag, req, irq_flag, 0);
        check(status == 8'hF8, req, status, 8'hF8);
    endtask

    task automatic run_txn(input bit gc, input bit arb, input int nbytes,
                           input logic [7:0] mask, input bit end_rs, input bit need_start);
        bit ack;
        bit engaged;
        logic [7:0] ab;
        ab = gc ? 8'h00 : {own_addr, 1'b0};
        if (need_start) bus_start();
        ack_enable = 1'b1; arb_lost = arb;
        send_byte(ab, ack);
        arb_lost = 1'b0;
        check(ack == 1'b1, gc ? "R3 addr ack" : "R2 addr ack", ack, 1);
        sw_expect(exp_addr(gc, arb), gc ? "R3" : "R2", ab, 1'b1);
        engaged = 1'b1;
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] d;
            string tag;
            d = 8'($urandom);
            ack_enable = mask[k];
            send_byte(d, ack);
            if (engaged) begin
                tag = gc ? "R5" : "R4";
                if (k > 0 && mask[k]) tag = "R6";
                check(ack == mask[k], tag, ack, mask[k]);
                sw_expect(exp_data(gc, mask[k]), tag, d, 1'b1);
                engaged = mask[k];
            end else begin
                check(!ack, "R8 no ack", ack, 0);
                sw_expect_none("R8 no flag");
            end
        end
        ack_enable = 1'b1;
        if (end_rs) bus_rstart(); else bus_stop();
        if (engaged) sw_expect(8'hA0, "R7", 8'h00, 1'b0);
        else sw_expect_none("R8 no A0");
    endtask

    task automatic run_ignored(input logic [7:0] ab, input bit aen, input bit gen, input string req);
        bit ack;
        bus_start();
        ack_enable = aen; gc_enable = gen;
        send_byte(ab, ack);
        check(!ack, req, ack, 0);
        sw_expect_none(req);
        ack_enable = 1'b1;
        send_byte(8'($urandom), ack);
        check(!ack, req, ack, 0);
        sw_expect_none(req);
        bus_stop();
        sw_expect_none(req);
        gc_enable = 1'b1;
    endtask

    initial begin
        bit prev_rs;
        void'($urandom(32'h5EED_2A1C));
        wait_clk(5);
        check(status == 8'hF8, "R1 status", status, 8'hF8);
        check(!irq_flag, "R1 flag", irq_flag, 0);
        check(!scl_drive_low && !sda_drive_low, "R1 drives", {scl_drive_low, sda_drive_low}, 0);
        rst = 1'b0;
        wait_clk(5);
        check(status == 8'hF8 && !irq_flag, "R1 after release", status, 8'hF8);

        // directed: own address, two acked bytes, refused byte, ignored byte
        run_txn(1'b0, 1'b0, 4, 8'b0011, 1'b0, 1'b1);
        // arbitration lost before own-address match
        run_txn(1'b0, 1'b1, 1, 8'b1, 1'b0, 1'b1);
        // general call, acked, acked, refused
        run_txn(1'b1, 1'b0, 3, 8'b011, 1'b0, 1'b1);
        run_txn(1'b1, 1'b1, 1, 8'b1, 1'b0, 1'b1);
        // repeated start while addressed, then a new address
        run_txn(1'b0, 1'b0, 2, 8'b11, 1'b1, 1'b1);
        run_txn(1'b0, 1'b0, 1, 8'b1, 1'b0, 1'b0);

        // R9 rejected address bytes
        run_ignored({7'h5B, 1'b0}, 1'b1, 1'b1, "R9 other addr");
        run_ignored({7'h5A, 1'b1}, 1'b1, 1'b1, "R9 read dir");
        run_ignored(8'h00,         1'b1, 1'b0, "R9 gc disabled");
        run_ignored({7'h5A, 1'b0}, 1'b0, 1'b1, "R9 ack refused");

        // random transactions
        prev_rs = 1'b0;
        for (int n = 0; n < 25; n++) begin
            bit gc, arb, rs;
            int nb;
            logic [7:0] msk;
            gc  = 1'($urandom);
            arb = ($urandom % 4) == 0;
            rs  = 1'($urandom);
            nb  = $urandom % 5;
            msk = 8'($urandom) | 8'h01;
            if (!prev_rs) begin
                own_addr = 7'($urandom % 127) + 7'd1;
            end
            run_txn(gc, arb, nb, msk, rs, !prev_rs);
            prev_rs = rs;
        end
        if (prev_rs) run_txn(1'b0, 1'b0, 1, 8'b1, 1'b0, 1'b0);

        check(r11_viol == 0, "R11 sda change while scl high", r11_viol, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule